// File: doc/BRIEF.md
# Staggered fingerprint-cell sampling sequencer

This block drives an array of free-running fingerprint cells, each an oscillator that a latch can stop, so that the cells are sampled one after another and never together. A one-cycle start pulse puts a single token at the bottom of a chain that is one stage longer than the cell count. The token climbs one stage per clock. The stage holding the token clears its own cell. The stage directly above it holds that cell's latch open. As a result, every cell gets one clock of clear, then one clock of open time, then a closed latch that holds its last level. Only one oscillator runs at any instant, which limits crosstalk between cells.

Every cell output passes through its own flip-flop. After the token leaves the top stage, a done cycle copies those flip-flops into the identifier register and releases busy. A full run takes CELLS+2 clocks from the start pulse, so each extra cell adds one clock. The oscillator cells are outside the block. In simulation they appear as plain input bits.

Top module: `puf_scan_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `busy`, `cell_clr`, `cell_open` and `id` are all zero after that edge.
- R2: `start` high at an edge while `busy` is low makes `busy` high after that edge, with `cell_clr` equal to 1 (bit 0 only) and `cell_open` zero.
- R3: During a run, the single set bit of `cell_clr` moves from bit k to bit k+1 on each clock. After cell CELLS-1 has been cleared, `cell_clr` is zero.
- R4: Bit k of `cell_open` is high for exactly the one clock that follows the clock in which bit k of `cell_clr` was high.
- R5: At most one bit of `cell_clr` and at most one bit of `cell_open` is high at any time.
- R6: `busy` stays high for exactly CELLS+2 clocks after an accepted start. In the cycle it falls, `id` bit k holds the value of `cell_in` bit k as sampled at the edge that ends the last open window.
- R7: `start` while `busy` is high has no effect: the run's timing and the captured `id` are those of the run already in progress.
- R8: `id` changes only at the edge where `busy` falls.
- R9: A start in the first cycle with `busy` low, directly after a run, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to sample the identifier |
| cell_in | input | CELLS | Output levels of the fingerprint cells |
| cell_clr | output | CELLS | Per-cell clear, high for one clock |
| cell_open | output | CELLS | Per-cell latch enable, high for one clock |
| busy | output | 1 | High while a run is in progress |
| id | output | CELLS | Captured identifier |

## Verification
The bench aims at the two ends of the token's path. If cell 0 or cell CELLS-1 lost its open window, or if the top stage were counted one clock too early or too late, `cell_open` and the fall of `busy` would drift off the model, or the top identifier bit would hold a stale sample. Starts are issued in the middle of a run and at its last cycle, and start is also held high for many cycles. A design that accepted any of these would restart the token, and its clear pattern would jump back to bit 0. A start arriving the cycle after busy drops checks that the idle test does not swallow a request. Changing the cell pattern partway through a run shows whether the design captures the levels at the end of the run or some earlier snapshot.

// File: rtl/puf_scan_seq.sv
module puf_scan_seq #(
  parameter int CELLS = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CELLS-1:0] cell_in,
  output logic [CELLS-1:0] cell_clr,
  output logic [CELLS-1:0] cell_open,
  output logic             busy,
  output logic [CELLS-1:0] id
);
  localparam int STAGES = CELLS + 1;

  logic [STAGES-1:0] tok;
  logic              done;
  logic [CELLS-1:0]  cell_q;
  logic              go;

  assign go        = start && !busy;
  assign busy      = (|tok) || done;
  assign cell_clr  = tok[CELLS-1:0];
  assign cell_open = tok[STAGES-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n)  tok <= '0;
    else if (go) tok <= STAGES'(1);
    else         tok <= tok << 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      cell_q <= '0;
      id     <= '0;
    end else begin
      done   <= tok[STAGES-1];
      cell_q <= cell_in;
      if (done) id <= cell_q;
    end
  end
endmodule

// File: rtl/puf_scan_seq_props.sv
module puf_scan_seq_props #(
  parameter int CELLS = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CELLS-1:0] cell_clr,
  input logic [CELLS-1:0] cell_open,
  input logic             busy,
  input logic [CELLS-1:0] id
);
  assert_clr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_clr));
  assert_open_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_open));
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cell_clr == CELLS'(1) && cell_open == '0));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !cell_clr[0]);
  assert_open_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (cell_open == $past(cell_clr)));
  assert_id_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(id));
endmodule

bind puf_scan_seq puf_scan_seq_props #(.CELLS(CELLS)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .cell_clr(cell_clr),
  .cell_open(cell_open), .busy(busy), .id(id)
);

// File: tb/puf_scan_seq_test.sv
module puf_scan_seq_test;
  localparam int CELLS = 96;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CELLS-1:0] cell_in = '0;
  logic [CELLS-1:0] cell_clr, cell_open, id;
  logic             busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  puf_scan_seq #(.CELLS(CELLS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cell_in(cell_in),
    .cell_clr(cell_clr), .cell_open(cell_open), .busy(busy), .id(id)
  );

  always #4 clk = ~clk;

  // behavioural reference: phase = clocks since accepted start, -1 when idle
  int               phase = -1;
  logic [CELLS-1:0] snap = '0;
  logic [CELLS-1:0] exp_id = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      phase = -1;
      exp_id = '0;
    end else if (phase < 0) begin
      if (start) phase = 0;
    end else if (phase == CELLS + 1) begin
      phase = -1;
      exp_id = snap;
    end else begin
      if (phase == CELLS) snap = cell_in;
      phase++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [CELLS-1:0] act,
                       input logic [CELLS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic [CELLS-1:0] e_clr, e_open;
    logic             e_busy;
    e_busy = (phase >= 0);
    e_clr  = (phase >= 0 && phase < CELLS) ? (CELLS'(1) << phase) : '0;
    e_open = (phase >= 1 && phase <= CELLS) ? (CELLS'(1) << (phase - 1)) : '0;
    check(busy === e_busy, "R6 busy", CELLS'(busy), CELLS'(e_busy));
    check(cell_clr === e_clr, "R3 cell_clr", cell_clr, e_clr);
    check(cell_open === e_open, "R4 cell_open", cell_open, e_open);
    check(id === exp_id, "R8 id", id, exp_id);
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && cell_clr === '0 && cell_open === '0 && id === '0,
          "R1 reset", {cell_clr[CELLS-1:1], busy}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R6: plain run, pattern A
    cell_in = {32'hA5C3_0F96, 32'h1234_5678, 32'hDEAD_BEEF};
    pulse_start();
    check(busy === 1'b1 && cell_clr === CELLS'(1), "R2 accept", cell_clr, CELLS'(1));
    wait_idle();
    check(id === {32'hA5C3_0F96, 32'h1234_5678, 32'hDEAD_BEEF}, "R6 capture A",
          id, {32'hA5C3_0F96, 32'h1234_5678, 32'hDEAD_BEEF});

    // R9: start right after busy falls
    cell_in = {CELLS{1'b1}};
    pulse_start();
    check(busy === 1'b1, "R9 back-to-back", CELLS'(busy), CELLS'(1));
    // R7: starts mid-run and near the end
    repeat (40) @(negedge clk);
    pulse_start();
    // pattern changes before the last open window ends: the final value counts
    cell_in = {48'h0, 48'hFFFF_0000_FFFF};
    repeat (50) @(negedge clk);
    pulse_start();
    check(busy === 1'b1, "R7 start ignored mid-run", CELLS'(busy), CELLS'(1));
    wait_idle();
    check(id === {48'h0, 48'hFFFF_0000_FFFF}, "R7 capture", id, {48'h0, 48'hFFFF_0000_FFFF});

    // R7: start held high continuously across runs
    cell_in = {CELLS/2{2'b10}};
    start = 1'b1;
    repeat (3 * (CELLS + 2) + 5) @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(id === {CELLS/2{2'b10}}, "R7 held start", id, {CELLS/2{2'b10}});

    // R8: idle with changing inputs leaves id alone
    cell_in = '0;
    repeat (20) @(negedge clk);
    check(id === {CELLS/2{2'b10}}, "R8 idle hold", id, {CELLS/2{2'b10}});

    // R1: reset mid-run
    pulse_start();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && id === '0, "R1 reset mid-run", id, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule